// File: doc/BRIEF.md
# Miss Target Service Selector

This block keeps the list of requests that were merged onto a single outstanding cache-line miss. When the line's fill response comes back, it decides which of those requests to complete. Each queued target records its origin (a CPU-side access or a snoop), a request id and the time it arrived. Targets are merged on the assumption that the fill will be a plain read response. When the fill arrives, the block walks the list in queue order and emits the selected targets one per cycle on a valid/ready stream. For each emitted target it reports the miss latency, and it keeps a running latency total for CPU targets.

An invalidating fill leaves the line unusable after the first CPU access, so completing more than one CPU target from it could break memory ordering. On such a fill the block completes the first CPU target and every snoop target only. The CPU targets behind the first one stay in the list. They are moved to the head of the list in their original order, and a one-cycle reissue pulse asks for a fresh line request on their behalf. When a fill leaves the list empty, a one-cycle free pulse releases the entry instead.

The controller has five states. IDLE accepts targets and responses. WALK steps through the list and emits the selected targets. PACK compacts the deferred targets. RELEASE raises the free pulse. REISSUE raises the reissue pulse. The transitions are:
- IDLE to WALK when a response is accepted.
- WALK to PACK once the walk passes the last entry.
- PACK to REISSUE if any target was deferred, otherwise PACK to RELEASE.
- RELEASE to IDLE and REISSUE to IDLE unconditionally.

Top module: `mshr_svc_top`

## Requirements
- R1: After reset the list is empty, and `svc_valid`, `rsp_ready`, `enq_stall`, `reissue`, `entry_free`, `err_illegal` and `lat_total` are all zero.
- R2: A target is appended at the tail when `enq_valid` is high and `enq_stall` is low. The list holds up to 8 targets. When it is full, `enq_stall` is high and an offered target is discarded.
- R3: On a plain response (`rsp_inval`=0), every legal target is emitted in queue order. `entry_free` then pulses for exactly one cycle and the list is empty.
- R4: On an invalidating response (`rsp_inval`=1), only the first CPU target and all snoop targets are emitted, in queue order.
- R5: On an invalidating response, the CPU targets after the first stay queued in their original relative order. `reissue` then pulses for exactly one cycle. `reissue` and `entry_free` are never high together.
- R6: The `rsp_alloc` value captured with a response appears on `svc_alloc` for every target emitted for that response.
- R7: `svc_latency` equals `now` minus the target's receive timestamp, modulo 2^16, sampled at the handshake. `lat_total` accumulates the latencies of the CPU targets only.
- R8: Source code 0 is CPU and 1 is snoop. A target with code 2 or 3 is never emitted: `err_illegal` is high for one cycle when the walk reaches it, and the target is dropped from the list.
- R9: While servicing is in progress, `rsp_ready` is low and `enq_stall` is high. `enq_stall` is also high in the cycle a response is accepted. A stalled emission holds its id and kind until `svc_ready`.
- R10: `rsp_ready` is high only in IDLE and only when the list is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Offer a target for the list |
| enq_kind | input | 2 | Source code: 0 CPU, 1 snoop, 2/3 illegal |
| enq_id | input | 4 | Request id |
| enq_ts | input | 16 | Receive timestamp |
| enq_stall | output | 1 | List full, block busy, or response being accepted |
| rsp_valid | input | 1 | Fill response present |
| rsp_inval | input | 1 | Fill carries an invalidate |
| rsp_alloc | input | 1 | Allocate-on-fill decision for this fill |
| rsp_ready | output | 1 | Response can be accepted |
| now | input | 16 | Current time for latency |
| svc_valid | output | 1 | A serviced target is presented |
| svc_ready | input | 1 | Consumer takes the serviced target |
| svc_kind | output | 2 | Source code of the serviced target |
| svc_id | output | 4 | Request id of the serviced target |
| svc_latency | output | 16 | Miss latency of the serviced target |
| svc_alloc | output | 1 | Allocate-on-fill for this batch |
| reissue | output | 1 | One-cycle request for a new line fetch |
| entry_free | output | 1 | One-cycle release of the entry |
| err_illegal | output | 1 | Walk reached an illegal source code |
| lat_total | output | 24 | Accumulated CPU miss latency |

## Verification
The hardest situation to reach is an invalidating fill over a list that interleaves several CPU and snoop targets. It must be followed by a second, plain fill that picks up the deferred CPU targets after compaction, and that checks the compaction kept their original order. The stimulus builds such mixed lists, sends an invalidating response, waits for the reissue pulse, and then sends a plain response over the compacted list. Meanwhile `svc_ready` is throttled in a repeating pattern, so that the held-output behaviour is exercised during the walk. Timestamps near the top of the 16-bit range make the latency wrap.

// File: rtl/mshr_sel_pkg.sv
package mshr_sel_pkg;

    typedef enum logic [1:0] {
        SRC_CPU   = 2'd0,
        SRC_SNOOP = 2'd1,
        SRC_RSV2  = 2'd2,
        SRC_RSV3  = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WALK,
        ST_PACK,
        ST_RELEASE,
        ST_REISSUE
    } svc_state_e;

endpackage

// File: rtl/mshr_tgt_list.sv
module mshr_tgt_list
    import mshr_sel_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ID_W  = 4,
    parameter int TS_W  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [1:0]       push_kind,
    input  logic [ID_W-1:0]  push_id,
    input  logic [TS_W-1:0]  push_ts,
    input  logic             pack,
    input  logic [DEPTH-1:0] keep,
    output logic [1:0]       kind_q [DEPTH],
    output logic [ID_W-1:0]  id_q   [DEPTH],
    output logic [TS_W-1:0]  ts_q   [DEPTH],
    output logic [CNT_W-1:0] cnt
);

    logic [1:0]       pk_kind [DEPTH];
    logic [ID_W-1:0]  pk_id   [DEPTH];
    logic [TS_W-1:0]  pk_ts   [DEPTH];
    logic [CNT_W-1:0] pk_cnt;

    // Compaction: kept entries slide to the head in their original order.
    always_comb begin
        pk_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            pk_kind[i] = '0;
            pk_id[i]   = '0;
            pk_ts[i]   = '0;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
                pk_kind[pk_cnt[IDX_W-1:0]] = kind_q[i];
                pk_id[pk_cnt[IDX_W-1:0]]   = id_q[i];
                pk_ts[pk_cnt[IDX_W-1:0]]   = ts_q[i];
                pk_cnt = pk_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                kind_q[i] <= '0;
                id_q[i]   <= '0;
                ts_q[i]   <= '0;
            end
        end else if (pack) begin
            cnt <= pk_cnt;
            for (int i = 0; i < DEPTH; i++) begin
                kind_q[i] <= pk_kind[i];
                id_q[i]   <= pk_id[i];
                ts_q[i]   <= pk_ts[i];
            end
        end else if (push) begin
            kind_q[cnt[IDX_W-1:0]] <= push_kind;
            id_q[cnt[IDX_W-1:0]]   <= push_id;
            ts_q[cnt[IDX_W-1:0]]   <= push_ts;
            cnt <= cnt + 1'b1;
        end
    end

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt < CNT_W'(DEPTH)));                          // R2
    AST_NO_PUSH_PACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pack));                                          // R9

endmodule

// File: rtl/mshr_pick.sv
module mshr_pick
    import mshr_sel_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [1:0]       kind_q [DEPTH],
    input  logic [CNT_W-1:0] cnt,
    input  logic             inval,
    output logic [DEPTH-1:0] sel,
    output logic [DEPTH-1:0] keep
);

    logic cpu_taken;

    always_comb begin
        sel       = '0;
        keep      = '0;
        cpu_taken = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(cnt)) begin
                unique case (kind_q[i])
                    SRC_CPU: begin
                        if (inval && cpu_taken) keep[i] = 1'b1;
                        else                    sel[i]  = 1'b1;
                        cpu_taken = 1'b1;
                    end
                    SRC_SNOOP: sel[i] = 1'b1;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/mshr_svc_fsm.sv
module mshr_svc_fsm
    import mshr_sel_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ID_W  = 4,
    parameter int TS_W  = 16,
    parameter int LAT_W = 24,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rsp_valid,
    input  logic             rsp_inval,
    input  logic             rsp_alloc,
    output logic             rsp_ready,
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       kind_q [DEPTH],
    input  logic [ID_W-1:0]  id_q   [DEPTH],
    input  logic [TS_W-1:0]  ts_q   [DEPTH],
    input  logic [DEPTH-1:0] sel_in,
    input  logic [DEPTH-1:0] keep_in,
    input  logic [TS_W-1:0]  now,
    input  logic             svc_ready,
    output logic             svc_valid,
    output logic [1:0]       svc_kind,
    output logic [ID_W-1:0]  svc_id,
    output logic [TS_W-1:0]  svc_latency,
    output logic             svc_alloc,
    output logic             busy,
    output logic             pack,
    output logic [DEPTH-1:0] keep_q,
    output logic             reissue,
    output logic             entry_free,
    output logic             err_illegal,
    output logic [LAT_W-1:0] lat_total
);

    svc_state_e       state, nxt;
    logic [CNT_W-1:0] idx;
    logic [DEPTH-1:0] sel_q;
    logic             alloc_q, inval_q, cpu_seen;
    logic             in_range, cur_sel, step, rsp_fire, svc_fire;
    logic [1:0]       cur_kind;

    assign in_range = idx < cnt;
    assign cur_kind = kind_q[idx[IDX_W-1:0]];
    assign cur_sel  = sel_q[idx[IDX_W-1:0]];
    assign step     = !cur_sel || svc_ready;
    assign rsp_fire = rsp_valid && rsp_ready;
    assign svc_fire = svc_valid && svc_ready;

    assign svc_kind    = cur_kind;
    assign svc_id      = id_q[idx[IDX_W-1:0]];
    assign svc_latency = now - ts_q[idx[IDX_W-1:0]];
    assign svc_alloc   = alloc_q;
    assign busy        = (state != ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Walk pointer, batch capture, latency accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            sel_q     <= '0;
            keep_q    <= '0;
            alloc_q   <= 1'b0;
            inval_q   <= 1'b0;
            cpu_seen  <= 1'b0;
            lat_total <= '0;
        end else if (rsp_fire) begin
            idx      <= '0;
            sel_q    <= sel_in;
            keep_q   <= keep_in;
            alloc_q  <= rsp_alloc;
            inval_q  <= rsp_inval;
            cpu_seen <= 1'b0;
        end else if (state == ST_WALK && in_range && step) begin
            idx <= idx + 1'b1;
            if (svc_fire && cur_kind == SRC_CPU) begin
                lat_total <= lat_total + LAT_W'(svc_latency);
                cpu_seen  <= 1'b1;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (rsp_fire) nxt = ST_WALK;
            ST_WALK:    if (!in_range) nxt = ST_PACK;
            ST_PACK:    nxt = (keep_q != '0) ? ST_REISSUE : ST_RELEASE;
            ST_RELEASE: nxt = ST_IDLE;
            ST_REISSUE: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rsp_ready   = 1'b0;
        svc_valid   = 1'b0;
        err_illegal = 1'b0;
        pack        = 1'b0;
        entry_free  = 1'b0;
        reissue     = 1'b0;
        unique case (state)
            ST_IDLE: rsp_ready = (cnt != '0);
            ST_WALK: begin
                if (in_range) begin
                    svc_valid   = cur_sel;
                    err_illegal = (cur_kind != SRC_CPU) && (cur_kind != SRC_SNOOP);
                end
            end
            ST_PACK:    pack       = 1'b1;
            ST_RELEASE: entry_free = 1'b1;
            ST_REISSUE: reissue    = 1'b1;
            default: ;
        endcase
    end

    AST_REISSUE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reissue |=> !reissue);                                     // R5
    AST_FREE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        entry_free |=> !entry_free);                               // R3
    AST_FREE_XOR_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reissue && entry_free));                                 // R5
    AST_SVC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_valid && !svc_ready) |=> (svc_valid && $stable(svc_id) && $stable(svc_kind))); // R9
    AST_INVAL_ONE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_q && svc_fire && svc_kind == SRC_CPU) |-> !cpu_seen); // R4
    AST_LEGAL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> (svc_kind == SRC_CPU || svc_kind == SRC_SNOOP)); // R8
    AST_NO_RSP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rsp_ready);                                      // R10

endmodule

// File: rtl/mshr_svc_top.sv
module mshr_svc_top
    import mshr_sel_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ID_W  = 4,
    parameter int TS_W  = 16,
    parameter int LAT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic [1:0]       enq_kind,
    input  logic [ID_W-1:0]  enq_id,
    input  logic [TS_W-1:0]  enq_ts,
    output logic             enq_stall,
    input  logic             rsp_valid,
    input  logic             rsp_inval,
    input  logic             rsp_alloc,
    output logic             rsp_ready,
    input  logic [TS_W-1:0]  now,
    output logic             svc_valid,
    input  logic             svc_ready,
    output logic [1:0]       svc_kind,
    output logic [ID_W-1:0]  svc_id,
    output logic [TS_W-1:0]  svc_latency,
    output logic             svc_alloc,
    output logic             reissue,
    output logic             entry_free,
    output logic             err_illegal,
    output logic [LAT_W-1:0] lat_total
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [1:0]       kind_q [DEPTH];
    logic [ID_W-1:0]  id_q   [DEPTH];
    logic [TS_W-1:0]  ts_q   [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [DEPTH-1:0] sel_w, keep_w, keep_q;
    logic             busy, pack, push;

    assign enq_stall = (cnt == CNT_W'(DEPTH)) || busy || (rsp_valid && rsp_ready);
    assign push      = enq_valid && !enq_stall;

    mshr_tgt_list #(.DEPTH(DEPTH), .ID_W(ID_W), .TS_W(TS_W)) u_list (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_kind(enq_kind), .push_id(enq_id), .push_ts(enq_ts),
        .pack(pack), .keep(keep_q),
        .kind_q(kind_q), .id_q(id_q), .ts_q(ts_q), .cnt(cnt)
    );

    mshr_pick #(.DEPTH(DEPTH)) u_pick (
        .kind_q(kind_q), .cnt(cnt), .inval(rsp_inval),
        .sel(sel_w), .keep(keep_w)
    );

    mshr_svc_fsm #(.DEPTH(DEPTH), .ID_W(ID_W), .TS_W(TS_W), .LAT_W(LAT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .rsp_valid(rsp_valid), .rsp_inval(rsp_inval), .rsp_alloc(rsp_alloc),
        .rsp_ready(rsp_ready),
        .cnt(cnt), .kind_q(kind_q), .id_q(id_q), .ts_q(ts_q),
        .sel_in(sel_w), .keep_in(keep_w),
        .now(now), .svc_ready(svc_ready),
        .svc_valid(svc_valid), .svc_kind(svc_kind), .svc_id(svc_id),
        .svc_latency(svc_latency), .svc_alloc(svc_alloc),
        .busy(busy), .pack(pack), .keep_q(keep_q),
        .reissue(reissue), .entry_free(entry_free),
        .err_illegal(err_illegal), .lat_total(lat_total)
    );

    AST_FREE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        entry_free |-> (cnt == '0));                               // R3
    AST_REISSUE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        reissue |-> (cnt != '0));                                  // R5

endmodule

// File: tb/test_mshr_svc_top.sv
`timescale 1ns/1ps
module test_mshr_svc_top;

    typedef struct {
        logic [1:0]  k;
        logic [3:0]  id;
        logic [15:0] t;
        logic        a;
    } tgt_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0;
    logic [1:0]  enq_kind = '0;
    logic [3:0]  enq_id = '0;
    logic [15:0] enq_ts = '0;
    logic        enq_stall;
    logic        rsp_valid = 1'b0, rsp_inval = 1'b0, rsp_alloc = 1'b0;
    logic        rsp_ready;
    logic [15:0] now = '0;
    logic        svc_valid, svc_ready = 1'b1;
    logic [1:0]  svc_kind;
    logic [3:0]  svc_id;
    logic [15:0] svc_latency;
    logic        svc_alloc, reissue, entry_free, err_illegal;
    logic [23:0] lat_total;

    int   checks = 0, errors = 0, cyc = 0, err_seen = 0, exp_err = 0;
    int   exp_total = 0;
    tgt_t mdl[$];
    tgt_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    mshr_svc_top i_mshr_svc_top (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_kind(enq_kind), .enq_id(enq_id), .enq_ts(enq_ts),
        .enq_stall(enq_stall),
        .rsp_valid(rsp_valid), .rsp_inval(rsp_inval), .rsp_alloc(rsp_alloc),
        .rsp_ready(rsp_ready), .now(now),
        .svc_valid(svc_valid), .svc_ready(svc_ready), .svc_kind(svc_kind),
        .svc_id(svc_id), .svc_latency(svc_latency), .svc_alloc(svc_alloc),
        .reissue(reissue), .entry_free(entry_free), .err_illegal(err_illegal),
        .lat_total(lat_total)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // time base and consumer throttle, changed just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            now = now + 16'd1;
            svc_ready = (cyc % 4) != 3;
        end
    end

    // watchdog
    initial begin
        wait (cyc > 150000);
        chk(0, "WATCHDOG", "run length", cyc, 150000);
        finish_run();
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && err_illegal) err_seen++;
            if (rst_n && svc_valid && svc_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "unexpected emission id", int'(svc_id), -1);
                end else begin
                    tgt_t e;
                    int   lat;
                    e = exp_q.pop_front();
                    lat = int'(16'(now - e.t));
                    chk(svc_id == e.id, "R3/R4", "svc_id", int'(svc_id), int'(e.id));
                    chk(svc_kind == e.k, "R8", "svc_kind", int'(svc_kind), int'(e.k));
                    chk(svc_alloc == e.a, "R6", "svc_alloc", int'(svc_alloc), int'(e.a));
                    chk(int'(svc_latency) == lat, "R7", "svc_latency", int'(svc_latency), lat);
                    if (e.k == 2'd0) exp_total = (exp_total + lat) & 24'hFFFFFF;
                end
            end
        end
    end

    task automatic push_tgt(input logic [1:0] k, input logic [3:0] id, input logic [15:0] t);
        @(posedge clk); #1;
        enq_valid = 1'b1; enq_kind = k; enq_id = id; enq_ts = t;
        @(negedge clk);
        if (!enq_stall) begin
            tgt_t n;
            n.k = k; n.id = id; n.t = t; n.a = 1'b0;
            mdl.push_back(n);
        end
        @(posedge clk); #1;
        enq_valid = 1'b0;
    endtask

    task automatic respond(input logic inval, input logic alloc);
        tgt_t keep_l[$];
        bit   first_cpu = 0;
        bit   want_reissue;
        int   wait_n = 0;
        foreach (mdl[i]) begin
            tgt_t e;
            e = mdl[i];
            e.a = alloc;
            if (e.k == 2'd0) begin
                if (inval && first_cpu) keep_l.push_back(e);
                else exp_q.push_back(e);
                first_cpu = 1;
            end else if (e.k == 2'd1) begin
                exp_q.push_back(e);
            end else begin
                exp_err++;
            end
        end
        mdl = keep_l;
        want_reissue = (keep_l.size() != 0);
        @(posedge clk); #1;
        rsp_valid = 1'b1; rsp_inval = inval; rsp_alloc = alloc;
        @(negedge clk);
        chk(rsp_ready == 1'b1, "R10", "rsp_ready idle non-empty", int'(rsp_ready), 1);
        chk(enq_stall == 1'b1, "R9", "stall on response cycle", int'(enq_stall), 1);
        @(posedge clk); #1;
        rsp_valid = 1'b0;
        @(negedge clk);
        chk(rsp_ready == 1'b0 && enq_stall == 1'b1, "R9", "busy blocks rsp/enq",
            int'({rsp_ready, enq_stall}), 1);
        while (!(reissue || entry_free) && wait_n < 300) begin
            @(negedge clk);
            wait_n++;
        end
        chk(reissue == want_reissue, "R5", "reissue pulse", int'(reissue), int'(want_reissue));
        chk(entry_free == !want_reissue, "R3", "entry_free pulse", int'(entry_free), int'(!want_reissue));
        chk(exp_q.size() == 0, "R4", "pending expected items", exp_q.size(), 0);
        chk(err_seen == exp_err, "R8", "illegal flags", err_seen, exp_err);
        chk(int'(lat_total) == exp_total, "R7", "lat_total", int'(lat_total), exp_total);
        @(negedge clk);
        chk(!reissue && !entry_free, "R5", "pulse length one", int'({reissue, entry_free}), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!svc_valid && !rsp_ready && !enq_stall, "R1", "idle outputs",
            int'({svc_valid, rsp_ready, enq_stall}), 0);
        chk(!reissue && !entry_free && !err_illegal && lat_total == 0, "R1", "pulses/total",
            int'({reissue, entry_free, err_illegal}), 0);

        // R3 plain fill, mixed kinds
        push_tgt(2'd0, 4'd1, now - 16'd5);
        push_tgt(2'd1, 4'd2, now);
        push_tgt(2'd0, 4'd3, now);
        respond(1'b0, 1'b1);

        // R4/R5 invalidating fill then plain over compacted list
        push_tgt(2'd0, 4'd4, now);
        push_tgt(2'd0, 4'd5, now);
        push_tgt(2'd1, 4'd6, now);
        push_tgt(2'd0, 4'd7, now);
        push_tgt(2'd1, 4'd8, now);
        push_tgt(2'd0, 4'd9, now);
        respond(1'b1, 1'b0);
        respond(1'b0, 1'b1);   // R5 order of deferred 5,7,9

        // R4 snoop first, only CPU after: invalidate twice
        push_tgt(2'd1, 4'd10, now);
        push_tgt(2'd0, 4'd11, now);
        push_tgt(2'd0, 4'd12, now);
        respond(1'b1, 1'b1);
        respond(1'b1, 1'b0);   // single remaining CPU -> free

        // R2 fill to capacity, ninth discarded
        for (int i = 0; i < 8; i++) push_tgt(2'(i % 2), 4'(i), now);
        @(negedge clk);
        chk(enq_stall == 1'b1, "R2", "stall when full", int'(enq_stall), 1);
        push_tgt(2'd0, 4'd15, now);
        chk(mdl.size() == 8, "R2", "model size", mdl.size(), 8);
        respond(1'b0, 1'b0);

        // R8 illegal kinds dropped; R7 latency wrap
        push_tgt(2'd2, 4'd1, now);
        push_tgt(2'd0, 4'd2, 16'hFFF0 + now);
        push_tgt(2'd3, 4'd3, now);
        push_tgt(2'd1, 4'd4, now);
        respond(1'b0, 1'b1);

        // R8 illegal in invalidating fill, deferred CPU survives
        push_tgt(2'd0, 4'd5, now);
        push_tgt(2'd2, 4'd6, now);
        push_tgt(2'd0, 4'd7, now);
        respond(1'b1, 1'b0);
        respond(1'b0, 1'b0);

        @(negedge clk);
        chk(rsp_ready == 1'b0, "R10", "rsp_ready when empty", int'(rsp_ready), 0);
        finish_run();
    end

endmodule